// File: doc/BRIEF.md
# Asynchronous Static RAM Sequencer

This block lets synchronous logic read and write an external asynchronous static RAM of one-bit words through a small request port. The host presents an address, a direction flag and one data bit while the sequencer is idle. The sequencer then drives the memory's chip-select, write strobe, address and write-data pins in a fixed pattern. Each phase lasts long enough to satisfy the memory's nanosecond timing minimums at the configured clock period.

Every phase length is worked out at elaboration. Each length is the ceiling of a timing figure in picoseconds divided by the clock-period parameter, with a floor of one cycle. Because of this, the same RTL serves any clock rate. All strobes and buses toward the memory come straight from flops. Between accesses the chip select is held inactive, which keeps the memory in its low-power standby state.

Top module: `sram_async_ctrl`

## Requirements
- R1: While reset is asserted and whenever no access is running, `sram_ce_n` and `sram_we_n` are 1, `rsp_done` is 0 and `req_ready` is 1.
- R2: A write holds `sram_ce_n` and `sram_we_n` both 0 for exactly NW cycles. NW = max(ceil(tPWE/P), ceil(tSCE/P), ceil(tAW/P), ceil(tSD/P), ceil(tWC/P)-1), where each term has a floor of 1 and P is the clock-period parameter. `sram_addr` and `sram_din` stay constant over that window, and `sram_we_n` is never 0 while `sram_ce_n` is 1.
- R3: A write is ended by `sram_we_n` rising while `sram_ce_n` stays 0. For one further cycle, address and write data keep their values, and then `sram_ce_n` rises.
- R4: A read holds `sram_ce_n`=0 and `sram_we_n`=1 for NR = max(ceil(tAA/P), ceil(tACE/P), ceil(tRC/P)) cycles. `sram_dout` is sampled at the edge where `sram_ce_n` rises, so `rsp_rdata` equals the bit last written at that address, or 0 if the address was never written.
- R5: `sram_addr` changes only while `sram_ce_n` is 1, or on the same edge where it falls. It never changes while the chip is selected.
- R6: `rsp_done` is a one-cycle pulse per access. It appears NW+1 edges after the accepting edge for a write and NR edges after it for a read. For a read, `rsp_rdata` is valid with the pulse and holds until the next read completes.
- R7: `req_ready` is 1 only while idle. A `req_valid` presented while `req_ready` is 0 is ignored: it starts no access and changes no memory contents.
- R8: Phase counts follow the period parameter. With P=2000 ps and the default timing figures, a write completes in 8 cycles and a read in 8 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Request strobe, taken when `req_ready` is 1 |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | 1 | Bit to write |
| req_ready | output | 1 | Sequencer idle and able to take a request |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 1 | Bit captured by the last read |
| sram_addr | output | ADDR_W | Memory address pins |
| sram_ce_n | output | 1 | Memory chip select, active low |
| sram_we_n | output | 1 | Memory write strobe, active low |
| sram_din | output | 1 | Memory write-data pin |
| sram_dout | input | 1 | Memory read-data pin |

## Verification
The bench builds two instances that share one 5 ns clock and one host port, each wired to its own timed memory model. The first uses the default 5000 ps period: all phases are three cycles long, and pulse width and enable time set the write window. The second declares a 2000 ps period on the same clock. That stretches writes to a 7-cycle window, now set by the write-cycle term, and reads to 8 cycles, so the count arithmetic is checked on a path where a different term wins. The models return inverted data to any read sampled before the access time has passed. They also tally strobe-order, hold and address-stability violations.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WR    = 2'd1,
    ST_WHOLD = 2'd2,
    ST_RD    = 2'd3
  } ctrl_state_e;

  // Whole clock cycles needed to cover t_ps, never fewer than one.
  function automatic int unsigned cyc_of(input int unsigned t_ps,
                                         input int unsigned per_ps);
    int unsigned c;
    c = (t_ps + per_ps - 1) / per_ps;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int unsigned umax(input int unsigned a,
                                       input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_rst_sync.sv
module sram_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign rst_sync_n = sync_q;
endmodule

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_nxt;

  always_comb begin
    cnt_nxt = cnt_q;
    if (load) begin
      cnt_nxt = load_val;
    end else if (cnt_q != '0) begin
      cnt_nxt = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_nxt;
    end
  end

  assign expired = (cnt_q == '0);

  // R8: once a phase has run out it stays out until reloaded
  assert_timer_rests_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (expired && !load) |=> expired);
endmodule

// File: rtl/sram_host_latch.sv
module sram_host_latch #(
  parameter int unsigned ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              data_in,
  output logic [ADDR_W-1:0] addr_q,
  output logic              data_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      data_q <= 1'b0;
    end else if (take) begin
      addr_q <= addr_in;
      data_q <= data_in;
    end
  end
endmodule

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W    = 20,
  parameter int unsigned CLK_PS    = 5000,
  parameter int unsigned T_WC_PS   = 15000,
  parameter int unsigned T_SCE_PS  = 12000,
  parameter int unsigned T_AW_PS   = 12000,
  parameter int unsigned T_PWE_PS  = 12000,
  parameter int unsigned T_SD_PS   = 8000,
  parameter int unsigned T_RC_PS   = 15000,
  parameter int unsigned T_AA_PS   = 15000,
  parameter int unsigned T_ACE_PS  = 15000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_wdata,
  output logic              req_ready,
  output logic              rsp_done,
  output logic              rsp_rdata,
  output logic [ADDR_W-1:0] sram_addr,
  output logic              sram_ce_n,
  output logic              sram_we_n,
  output logic              sram_din,
  input  logic              sram_dout
);
  // Phase lengths in cycles
  localparam int unsigned N_WC  = cyc_of(T_WC_PS, CLK_PS);
  localparam int unsigned N_WC1 = (N_WC > 1) ? N_WC - 1 : 1;
  localparam int unsigned N_WR  = umax(umax(umax(cyc_of(T_PWE_PS, CLK_PS),
                                                 cyc_of(T_SCE_PS, CLK_PS)),
                                            umax(cyc_of(T_AW_PS, CLK_PS),
                                                 cyc_of(T_SD_PS, CLK_PS))),
                                       N_WC1);
  localparam int unsigned N_RD  = umax(umax(cyc_of(T_AA_PS, CLK_PS),
                                            cyc_of(T_ACE_PS, CLK_PS)),
                                       cyc_of(T_RC_PS, CLK_PS));
  localparam int unsigned N_MAX = umax(N_WR, N_RD);
  localparam int unsigned CNT_W = (N_MAX < 2) ? 1 : $clog2(N_MAX);
  localparam logic [CNT_W-1:0] LD_WR = CNT_W'(N_WR - 1);
  localparam logic [CNT_W-1:0] LD_RD = CNT_W'(N_RD - 1);

  logic             rst_sync_n;
  ctrl_state_e      state_q, state_nxt;
  logic             take;
  logic             tmr_load;
  logic [CNT_W-1:0] tmr_val;
  logic             tmr_expired;
  logic             ce_n_q, ce_n_nxt;
  logic             we_n_q, we_n_nxt;
  logic             done_q, done_nxt;
  logic             rdata_q;
  logic             cap_en;

  sram_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  sram_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_expired)
  );

  sram_host_latch #(.ADDR_W(ADDR_W)) u_latch (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .take    (take),
    .addr_in (req_addr),
    .data_in (req_wdata),
    .addr_q  (sram_addr),
    .data_q  (sram_din)
  );

  // Next-state logic
  always_comb begin
    state_nxt = state_q;
    take      = 1'b0;
    tmr_load  = 1'b0;
    tmr_val   = '0;
    unique case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          take     = 1'b1;
          tmr_load = 1'b1;
          if (req_write) begin
            state_nxt = ST_WR;
            tmr_val   = LD_WR;
          end else begin
            state_nxt = ST_RD;
            tmr_val   = LD_RD;
          end
        end
      end
      ST_WR:    if (tmr_expired) state_nxt = ST_WHOLD;
      ST_WHOLD: state_nxt = ST_IDLE;
      ST_RD:    if (tmr_expired) state_nxt = ST_IDLE;
      default:  state_nxt = ST_IDLE;
    endcase
  end

  always_comb begin
    ce_n_nxt = (state_nxt == ST_IDLE);
    we_n_nxt = (state_nxt != ST_WR);
    cap_en   = (state_q == ST_RD) && tmr_expired;
    done_nxt = (state_q == ST_WHOLD) || cap_en;
  end

  // Registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      state_q <= ST_IDLE;
      ce_n_q  <= 1'b1;
      we_n_q  <= 1'b1;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_nxt;
      ce_n_q  <= ce_n_nxt;
      we_n_q  <= we_n_nxt;
      done_q  <= done_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      rdata_q <= 1'b0;
    end else if (cap_en) begin
      rdata_q <= sram_dout;
    end
  end

  assign req_ready = (state_q == ST_IDLE);
  assign rsp_done  = done_q;
  assign rsp_rdata = rdata_q;
  assign sram_ce_n = ce_n_q;
  assign sram_we_n = we_n_q;

  // R2: the write strobe lives only inside a chip select
  assert_we_inside_ce_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !sram_we_n |-> !sram_ce_n);
  // R3: the write ends on the write strobe, chip stays selected
  assert_we_ends_write_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(sram_we_n) |-> !sram_ce_n);
  // R3: write data held for the cycle after the strobe rises
  assert_din_hold_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(sram_we_n) |=> $stable(sram_din));
  // R5: address never moves during a selected access
  assert_addr_steady_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!sram_ce_n && $past(!sram_ce_n)) |-> $stable(sram_addr));
  // R6: completion is a single-cycle pulse
  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    rsp_done |=> !rsp_done);
  // R7: ready only while the memory is deselected
  assert_ready_idle_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    req_ready |-> (sram_ce_n && sram_we_n));
  // R4: a read keeps the write strobe off
  assert_read_strobes_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (state_q == ST_RD) |-> (sram_we_n && !sram_ce_n));
endmodule

// File: tb/tb_sram_async_ctrl.sv
`timescale 1ns/1ps

module sram_bit_model #(
  parameter int PER_PS   = 5000,
  parameter int T_PWE_PS = 12000,
  parameter int T_ACC_PS = 15000
) (
  input  logic        clk,
  input  logic        ce_n,
  input  logic        we_n,
  input  logic [19:0] addr,
  input  logic        din,
  output logic        dout,
  output int          err_wr,
  output int          err_hold,
  output int          err_addr,
  output int          ov_last
);
  bit mem [logic [19:0]];
  logic        p_ce_n = 1'b1;
  logic        p_we_n = 1'b1;
  logic [19:0] p_addr = '0;
  logic        p_din  = 1'b0;
  int          ovc    = 0;
  int          rage   = 0;

  function automatic logic peek(input logic [19:0] a);
    return mem.exists(a) ? mem[a] : 1'b0;
  endfunction

  initial begin
    dout = 1'b0; err_wr = 0; err_hold = 0; err_addr = 0; ov_last = 0;
  end

  always @(negedge clk) begin
    logic both, p_both, v;
    both   = !ce_n && !we_n;
    p_both = !p_ce_n && !p_we_n;
    if (!we_n && ce_n) err_wr++;
    if (both) begin
      ovc = p_both ? ovc + 1 : 1;
      if (p_both && (addr != p_addr || din != p_din)) err_wr++;
    end
    if (p_both && !both) begin
      ov_last = ovc;
      if (ovc * PER_PS < T_PWE_PS) err_wr++;
      if (ce_n || din != p_din) err_hold++;
      mem[p_addr] = p_din;
    end
    if (!ce_n && !p_ce_n && addr != p_addr) err_addr++;
    if (!ce_n && we_n) begin
      rage = (!p_ce_n && p_we_n && addr == p_addr) ? rage + 1 : 1;
      v = peek(addr);
      dout = (rage * PER_PS >= T_ACC_PS) ? v : !v;
    end else begin
      rage = 0;
      dout = 1'b0;
    end
    p_ce_n = ce_n; p_we_n = we_n; p_addr = addr; p_din = din;
  end
endmodule

module tb_sram_async_ctrl;
  logic clk = 1'b0;
  logic rst_n;
  logic req_valid, req_write, req_wdata;
  logic [19:0] req_addr;

  logic ready0, done0, rdata0, ce0, we0, din0, dout0;
  logic ready1, done1, rdata1, ce1, we1, din1, dout1;
  logic [19:0] addr0, addr1;
  int ew0, eh0, ea0, ov0, ew1, eh1, ea1, ov1;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  sram_async_ctrl dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(ready0),
    .rsp_done(done0), .rsp_rdata(rdata0), .sram_addr(addr0),
    .sram_ce_n(ce0), .sram_we_n(we0), .sram_din(din0), .sram_dout(dout0));

  sram_async_ctrl #(.CLK_PS(2000)) dut_fine (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(ready1),
    .rsp_done(done1), .rsp_rdata(rdata1), .sram_addr(addr1),
    .sram_ce_n(ce1), .sram_we_n(we1), .sram_din(din1), .sram_dout(dout1));

  sram_bit_model mdl0 (.clk(clk), .ce_n(ce0), .we_n(we0), .addr(addr0),
    .din(din0), .dout(dout0), .err_wr(ew0), .err_hold(eh0), .err_addr(ea0),
    .ov_last(ov0));
  sram_bit_model mdl1 (.clk(clk), .ce_n(ce1), .we_n(we1), .addr(addr1),
    .din(din1), .dout(dout1), .err_wr(ew1), .err_hold(eh1), .err_addr(ea1),
    .ov_last(ov1));

  function automatic int cdiv(input int t, input int p);
    int c;
    c = (t + p - 1) / p;
    return (c < 1) ? 1 : c;
  endfunction
  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
  function automatic int wcyc(input int p);
    return imax(imax(cdiv(12000, p), cdiv(8000, p)), cdiv(15000, p) - 1);
  endfunction
  function automatic int rcyc(input int p);
    return cdiv(15000, p);
  endfunction

  localparam int NW0 = 3, NR0 = 3;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic access(input logic wr, input logic [19:0] a, input logic d,
                        input bit intrude,
                        output logic r0, output logic r1,
                        output int l0, output int l1,
                        output int p0, output int p1);
    int k;
    bit s0, s1;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    k = 0; s0 = 0; s1 = 0; l0 = -1; l1 = -1; p0 = 0; p1 = 0; r0 = 0; r1 = 0;
    while (!(s0 && s1) && k < 200) begin
      @(posedge clk);
      k++;
      @(negedge clk);
      if (intrude && k == 1) begin
        chk(!ready0 && !ready1, "R7", "ready while busy", ready0 + ready1, 0);
        req_valid = 1'b1; req_write = 1'b1; req_addr = 20'h0BBBB; req_wdata = 1'b1;
      end
      if (intrude && k == 2) req_valid = 1'b0;
      if (done0) begin p0++; if (!s0) begin s0 = 1; l0 = k; r0 = rdata0; end end
      if (done1) begin p1++; if (!s1) begin s1 = 1; l1 = k; r1 = rdata1; end end
    end
    @(negedge clk);
    if (done0) p0++;
    if (done1) p1++;
  endtask

  // {write, addr[19:0], wdata, expected read}
  localparam int NV = 13;
  localparam logic [22:0] VEC [NV] = '{
    {1'b1, 20'h00000, 1'b1, 1'b0},
    {1'b1, 20'hFFFFF, 1'b1, 1'b0},
    {1'b1, 20'h12345, 1'b0, 1'b0},
    {1'b1, 20'h12346, 1'b1, 1'b0},
    {1'b0, 20'h00000, 1'b0, 1'b1},
    {1'b0, 20'hFFFFF, 1'b0, 1'b1},
    {1'b0, 20'h12345, 1'b0, 1'b0},
    {1'b0, 20'h12346, 1'b0, 1'b1},
    {1'b1, 20'h00000, 1'b0, 1'b0},
    {1'b0, 20'h00000, 1'b0, 1'b0},
    {1'b0, 20'h54321, 1'b0, 1'b0},
    {1'b1, 20'h54321, 1'b1, 1'b0},
    {1'b0, 20'h54321, 1'b0, 1'b1}
  };

  initial begin
    #(200000 * 5);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic r0, r1;
    int l0, l1, p0, p1;
    int nw1, nr1;
    nw1 = wcyc(2000);
    nr1 = rcyc(2000);
    req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = 1'b0;
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    // R1: reset state
    chk(ce0 && we0 && ce1 && we1, "R1", "strobes in reset", {ce0, we0}, 3);
    chk(!done0 && !done1 && ready0 && ready1, "R1", "done/ready in reset",
        {done0, ready0}, 1);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(ce0 && we0 && ready0 && !done0, "R1", "idle after reset", {ce0, we0, ready0}, 7);

    for (int i = 0; i < NV; i++) begin
      access(VEC[i][22], VEC[i][21:2], VEC[i][1], 1'b0, r0, r1, l0, l1, p0, p1);
      if (VEC[i][22]) begin
        chk(l0 == NW0 + 1, "R6", "write latency", l0, NW0 + 1);
        chk(ov0 == NW0, "R2", "write window cycles", ov0, NW0);
        chk(l1 == nw1 + 1, "R8", "fine write latency", l1, nw1 + 1);
        chk(ov1 == nw1, "R8", "fine write window", ov1, nw1);
      end else begin
        chk(l0 == NR0, "R6", "read latency", l0, NR0);
        chk(r0 == VEC[i][0], "R4", "read data", r0, VEC[i][0]);
        chk(l1 == nr1, "R8", "fine read latency", l1, nr1);
        chk(r1 == VEC[i][0], "R4", "fine read data", r1, VEC[i][0]);
      end
      chk(p0 == 1 && p1 == 1, "R6", "done pulse count", p0 * 10 + p1, 11);
      chk(ce0 && we0 && ce1 && we1, "R1", "deselected after access", {ce0, we0}, 3);
    end

    // R7: request during a busy write is dropped
    access(1'b1, 20'h0AAAA, 1'b1, 1'b1, r0, r1, l0, l1, p0, p1);
    chk(p0 == 1 && p1 == 1, "R7", "one access for two strobes", p0 * 10 + p1, 11);
    repeat (3) @(negedge clk);
    chk(ready0 && ce0, "R7", "no access started by ignored request", {ready0, ce0}, 3);
    access(1'b0, 20'h0BBBB, 1'b0, 1'b0, r0, r1, l0, l1, p0, p1);
    chk(r0 == 1'b0 && r1 == 1'b0, "R7", "ignored write not stored", r0 + r1, 0);
    access(1'b0, 20'h0AAAA, 1'b0, 1'b0, r0, r1, l0, l1, p0, p1);
    chk(r0 == 1'b1 && r1 == 1'b1, "R4", "readback after intrusion", r0 + r1, 2);
    // R6: read data holds across a following write
    access(1'b1, 20'h0AAAA, 1'b0, 1'b0, r0, r1, l0, l1, p0, p1);
    chk(rdata0 == 1'b1 && rdata1 == 1'b1, "R6", "rdata held over write", rdata0 + rdata1, 2);

    chk(ew0 == 0 && ew1 == 0, "R2", "write window violations", ew0 + ew1, 0);
    chk(eh0 == 0 && eh1 == 0, "R3", "write end/hold violations", eh0 + eh1, 0);
    chk(ea0 == 0 && ea1 == 0, "R5", "address moved while selected", ea0 + ea1, 0);

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule